// File: doc/BRIEF.md
# Double-Buffered Pulse Generation Timer

This block is a parameterised up-counting timer with two compare registers. It advances once per cycle in which the prescaled tick input is high and the run bit is set. The period register, `cmp1`, sets the wrap point. The low compare register, `cmp0`, marks a point inside the period. Each match can raise its own single-cycle interrupt pulse, and each of these pulses is gated by its own enable.

There are two modes. In interval mode the timer only produces periodic `cmp1` interrupts, and the output pin rests at its inactive level. In pulse mode an internal toggle flip-flop inverts at each of the two matches and drives the output pin. The result is a square wave whose frequency comes from `cmp1` and whose duty comes from `cmp0`. Pulse mode requires `cmp0 < cmp1`. A polarity input chooses whether the pulse is active high or active low. With double buffering on, software can rewrite `cmp0` at any time, and the new value is applied only at the next period boundary. This keeps the waveform free of glitches.

Top module: `ppg_timer`

## Requirements
- R1: The counter starts at 0 when run is set and advances by one only in cycles where both run and tick are high.
- R2: When the counter equals `cmp1` on an advancing cycle, it returns to 0 on that edge, so one period lasts `cmp1`+1 ticks.
- R3: In interval mode with `irq1_en` high, `irq1` is high for exactly the one cycle in which the `cmp1` match is detected, once per period.
- R4: In pulse mode the toggle flip-flop starts inactive and inverts at the `cmp0` match and again at the `cmp1` match. With active-high polarity, the pin is high while the count lies in `cmp0`+1 .. `cmp1`.
- R5: With `active_low` = 1 the pin is the inverse of its active-high waveform.
- R6: Clearing run returns the counter to 0 and puts the pin at its inactive level (0 for active high, 1 for active low). After a restart, the counter counts again from 0.
- R7: `irq0` pulses in the cycle of a `cmp0` match when `irq0_en` is high. With an enable low, the corresponding interrupt stays low.
- R8: With `dbuf_en` = 1, a write to `cmp0` (`wr_sel` = 0) goes to a buffer that is copied into the active `cmp0` only at a `cmp1` match.
- R9: With `dbuf_en` = 0, a write to `cmp0` is in effect from the next cycle. A write with `wr_sel` = 1 always updates `cmp1` directly.
- R10: In interval mode the pin stays at its inactive level.
- R11: After reset the counter and compare registers are 0, both interrupts are low and the pin is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable |
| run | input | 1 | Run bit; low stops and clears the counter |
| pulse_mode | input | 1 | 1 = pulse generation, 0 = interval |
| dbuf_en | input | 1 | Double buffering for `cmp0` |
| active_low | input | 1 | Output polarity, 1 = active low |
| irq0_en | input | 1 | Enable for the `cmp0` match interrupt |
| irq1_en | input | 1 | Enable for the `cmp1` match interrupt |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | 0 = `cmp0`, 1 = `cmp1` |
| wr_data | input | CW | Write data |
| pulse_out | output | 1 | Output pin level |
| irq0 | output | 1 | `cmp0` match interrupt pulse |
| irq1 | output | 1 | `cmp1` match interrupt pulse |

## Verification
The bench builds the timer with the default width `CW` = 16 and uses small compare values (1 to 5). Every wrap, toggle and buffer transfer therefore falls within a few dozen cycles, and each edge can be checked cycle by cycle against an index computed from the requirements. Gating the tick on alternate cycles stretches the period to twice `cmp1`+1 cycles, which separates counting ticks from counting clocks.

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          pulse_mode,
  input  logic          dbuf_en,
  input  logic          active_low,
  input  logic          irq0_en,
  input  logic          irq1_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic          pulse_out,
  output logic          irq0,
  output logic          irq1
);

  logic [CW-1:0] cnt_q, cmp0_q, cmp0_nxt_q, cmp1_q;
  logic          tog_q;

  wire adv  = run & tick;
  wire hit0 = adv && (cnt_q == cmp0_q);
  wire hit1 = adv && (cnt_q == cmp1_q);
  wire wr0  = wr_en & ~wr_sel;
  wire wr1  = wr_en &  wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= hit1 ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cmp1_q <= '0;
    else if (wr1) cmp1_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cmp0_nxt_q <= '0;
    else if (wr0) cmp0_nxt_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cmp0_q <= '0;
    else if (wr0 && !dbuf_en)   cmp0_q <= wr_data;
    else if (dbuf_en && hit1)   cmp0_q <= cmp0_nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tog_q <= 1'b0;
    else if (!run || !pulse_mode) tog_q <= 1'b0;
    else                          tog_q <= tog_q ^ hit0 ^ hit1;
  end

  assign pulse_out = tog_q ^ active_low;
  assign irq0      = hit0 & irq0_en;
  assign irq1      = hit1 & irq1_en;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q != cmp1_q) |=> (!run || cnt_q == CW'($past(cnt_q) + 1'b1)) || !$past(run));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> cnt_q == '0);

  // R3
  irq1_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |=> cnt_q == '0);

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !tog_q);

  // R8
  dbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !hit1) |=> $stable(cmp0_q));

  // R9
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !dbuf_en) |=> cmp0_q == $past(wr_data));

endmodule

// File: tb/ppg_timer_tb.sv
module ppg_timer_tb;
  localparam int CLK_P = 10;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, run = 1'b0, pulse_mode = 1'b0, dbuf_en = 1'b0, active_low = 1'b0;
  logic irq0_en = 1'b0, irq1_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic pulse_out, irq0, irq1;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ppg_timer #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .pulse_mode(pulse_mode),
    .dbuf_en(dbuf_en), .active_low(active_low), .irq0_en(irq0_en), .irq1_en(irq1_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pulse_out(pulse_out), .irq0(irq0), .irq1(irq1));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stop_timer();
    @(negedge clk); run = 1'b0; tick = 1'b1; wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input int d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = CW'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    #4;
    chk("R11 pin", pulse_out, 0);
    chk("R11 irq0", irq0, 0);
    chk("R11 irq1", irq1, 0);
  endtask

  task automatic t_interval();
    stop_timer(); pulse_mode = 1'b0; irq1_en = 1'b1; irq0_en = 1'b0;
    wr(1'b1, 4);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); if (i == 0) run = 1'b1;
      #4;
      chk("R2 R3 irq1", irq1, (i % 5 == 4) ? 1 : 0);
      chk("R10 pin", pulse_out, 0);
    end
  endtask

  task automatic t_ppg(input logic low);
    stop_timer(); pulse_mode = 1'b1; active_low = low; irq1_en = 1'b0;
    wr(1'b0, 2); wr(1'b1, 5);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk); if (i == 0) run = 1'b1;
      #4;
      if (low) chk("R5 pin", pulse_out, ((i % 6) >= 3) ? 0 : 1);
      else     chk("R4 pin", pulse_out, ((i % 6) >= 3) ? 1 : 0);
    end
    @(negedge clk); run = 1'b0;
    @(negedge clk); #4;
    chk("R6 idle pin", pulse_out, low ? 1 : 0);
    active_low = 1'b0;
  endtask

  task automatic t_irq0();
    stop_timer(); pulse_mode = 1'b0; irq0_en = 1'b1; irq1_en = 1'b0;
    wr(1'b0, 1); wr(1'b1, 3);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (i == 0) run = 1'b1;
      #4;
      chk("R7 irq0", irq0, (i % 4 == 1) ? 1 : 0);
      chk("R7 irq1 off", irq1, 0);
    end
  endtask

  task automatic t_buffer(input logic buffered);
    stop_timer(); pulse_mode = 1'b0; dbuf_en = 1'b0; irq0_en = 1'b1; irq1_en = 1'b0;
    wr(1'b0, 1); wr(1'b1, 5);
    dbuf_en = buffered;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (i == 0) begin run = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = CW'(3); end
      if (i == 1) wr_en = 1'b0;
      #4;
      if (buffered) chk("R8 irq0", irq0, (i == 1 || (i >= 6 && i % 6 == 3)) ? 1 : 0);
      else          chk("R9 irq0", irq0, (i % 6 == 3) ? 1 : 0);
    end
    dbuf_en = 1'b0;
  endtask

  task automatic t_tick();
    stop_timer(); pulse_mode = 1'b0; irq0_en = 1'b0; irq1_en = 1'b1;
    wr(1'b1, 2);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk); if (i == 0) run = 1'b1;
      tick = (i % 2 == 0);
      #4;
      chk("R1 gated irq1", irq1, (i % 6 == 4) ? 1 : 0);
    end
    tick = 1'b1;
  endtask

  task automatic t_restart();
    stop_timer(); pulse_mode = 1'b0; irq1_en = 1'b1;
    wr(1'b1, 4);
    @(negedge clk); run = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (i == 0) run = 1'b1;
      #4;
      chk("R6 restart irq1", irq1, (i % 5 == 4) ? 1 : 0);
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_interval();
    t_ppg(1'b0);
    t_ppg(1'b1);
    t_irq0();
    t_buffer(1'b1);
    t_buffer(1'b0);
    t_tick();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule